// File: doc/BRIEF.md
# Infrared Run-Length Receive Sampler

The block watches one demodulated infrared line and turns it into a stream of run-length bytes. A 1 MHz tick is divided down to a programmable sample period. On every sample strobe the synchronised line level is compared with the polarity of the run in progress. When the level changes, the finished run is written as one byte into a small circular buffer. The write pointer then advances, and a sticky receive interrupt flag can be raised.

Each byte holds a space flag in bit 7 (1 = space, 0 = mark) and the run length in sample periods in bits 6:0. Runs longer than the 7-bit limit can be cut into several entries of the same polarity. Because of this, a silent line keeps producing full-length space entries until software drops the enable bit and raises it again. The host reads the buffer through a combinational read port and follows the hardware write pointer.

A three-state machine controls the receiver. State ST_OFF is held while the enable bit is low. ST_OFF moves to ST_ARM on the first cycle that the enable bit is high. ST_ARM moves to ST_RUN on the first sample strobe, which takes that sample's level as the run polarity with a count of 1. ST_RUN stays in ST_RUN on every strobe: it either extends the run, splits it, or closes it and opens the opposite run. Any state moves back to ST_OFF as soon as the enable bit is low, and the open run is then discarded.

Top module: `irrl_sampler`

## Requirements
- R1: An entry is written as {space, duration[6:0]}. Bit 7 is 1 for a space and 0 for a mark. With cfg_invert=0, ir_in=1 is a mark. A duration is never 0.
- R2: Each entry goes to the slot addressed by wr_ptr, and wr_ptr then steps by one. From 7 it wraps to 0. rd_data always shows the slot selected by rd_addr.
- R3: A sample happens on every cfg_period-th us_tick after enable. The first sample after enable opens a run with a count of 1. Each later sample of the same level adds 1, and a level change closes the run with its count.
- R4: A cfg_period value below 5 is replaced by the default of 50 ticks.
- R5: With cfg_ovf_en=1, a run that already holds 127 and sees one more sample of the same level emits an entry of 127 and restarts its count at 1.
- R6: With cfg_ovf_en=0, the count stops at 127, and the run yields a single entry of 127 when it closes.
- R7: With cfg_ovf_en=1, an idle line emits space entries of 127 repeatedly. Clearing cfg_rx_en drops the open run and stops all writes. After enable is set again, a fresh run starts.
- R8: rx_irq goes to 1 in the cycle after an entry is written, but only if cfg_irq_en was 1. It then holds until a cycle with irq_clr=1. With cfg_irq_en=0 it is never set.
- R9: cfg_invert=1 swaps the meaning of the line, so ir_in=0 is a mark.
- R10: After reset, wr_ptr=0, rx_irq=0 and every buffer slot reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe at 1 MHz |
| ir_in | input | 1 | Demodulated infrared line (asynchronous) |
| cfg_rx_en | input | 1 | Receive enable; low resets the run logic |
| cfg_irq_en | input | 1 | Allows rx_irq to be set |
| cfg_ovf_en | input | 1 | Split long runs into 127-count entries |
| cfg_invert | input | 1 | Invert line polarity |
| cfg_period | input | 7 | Ticks per sample, valid range 5 to 127 |
| irq_clr | input | 1 | Write-one clear of rx_irq |
| rd_addr | input | 3 | Buffer slot to read |
| rd_data | output | 8 | Contents of the selected slot |
| wr_ptr | output | 3 | Slot the next entry will occupy |
| rx_irq | output | 1 | Sticky receive interrupt flag |

## Verification
The assertions assume that cfg_irq_en, cfg_ovf_en, cfg_invert and cfg_period are changed only while the receiver is disabled. They also assume that ir_in stays steady for several clocks around each sample strobe. The stimulus respects both. Configuration is changed only after cfg_rx_en is dropped. The line is moved only at least three clocks before the first tick of a sample window, and it is held until three clocks after that window's last tick, so every sample sees a settled, synchronised level. Random run lengths and sample periods are drawn inside the legal ranges. Splitting, saturation and the period fallback are then driven directly.

// File: rtl/irrl_pkg.sv
package irrl_pkg;
    localparam int DUR_W   = 7;
    localparam int ENTRY_W = DUR_W + 1;
    localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } rx_state_t;

    // A mark is stored with the space flag cleared.
    function automatic logic [ENTRY_W-1:0] pack_entry(input logic mark,
                                                      input logic [DUR_W-1:0] dur);
        return {~mark, dur};
    endfunction
endpackage

// File: rtl/irrl_sync.sv
module irrl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic invert,
    output logic level
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], din};
    end

    assign level = shreg[STAGES-1] ^ invert;
endmodule

// File: rtl/irrl_prescale.sv
module irrl_prescale #(
    parameter int PERIOD_W   = 7,
    parameter int MIN_PERIOD = 5,
    parameter int DEF_PERIOD = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period,
    output logic                strobe
);
    localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);
    localparam logic [PERIOD_W-1:0] DEF_P = PERIOD_W'(DEF_PERIOD);

    logic [PERIOD_W-1:0] eff;
    logic [PERIOD_W-1:0] cnt;

    assign eff = (period < MIN_P) ? DEF_P : period;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else if (!enable) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (tick) begin
                if (cnt == eff - 1'b1) begin
                    cnt    <= '0;
                    strobe <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irrl_ring.sv
module irrl_ring #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [W-1:0]             rd_data,
    output logic [$clog2(DEPTH)-1:0] wr_ptr
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_ptr == PW'(i)) mem[i] <= wr_data;
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/irrl_sampler.sv
module irrl_sampler #(
    parameter int DEPTH       = 8,
    parameter int PERIOD_W    = 7,
    parameter int MIN_PERIOD  = 5,
    parameter int DEF_PERIOD  = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     us_tick,
    input  logic                     ir_in,
    input  logic                     cfg_rx_en,
    input  logic                     cfg_irq_en,
    input  logic                     cfg_ovf_en,
    input  logic                     cfg_invert,
    input  logic [PERIOD_W-1:0]      cfg_period,
    input  logic                     irq_clr,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [7:0]               rd_data,
    output logic [$clog2(DEPTH)-1:0] wr_ptr,
    output logic                     rx_irq
);
    import irrl_pkg::*;

    logic                 level;
    logic                 strobe;
    rx_state_t            state, nxt_state;
    logic                 run_mark, nxt_mark;
    logic [DUR_W-1:0]     run_cnt, nxt_cnt;
    logic                 wr_en;
    logic [ENTRY_W-1:0]   wr_data;

    irrl_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(ir_in), .invert(cfg_invert), .level(level)
    );

    irrl_prescale #(
        .PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD), .DEF_PERIOD(DEF_PERIOD)
    ) i_pre (
        .clk(clk), .rst_n(rst_n), .enable(cfg_rx_en), .tick(us_tick),
        .period(cfg_period), .strobe(strobe)
    );

    irrl_ring #(.DEPTH(DEPTH), .W(ENTRY_W)) i_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            run_mark <= 1'b0;
            run_cnt  <= '0;
        end else begin
            state    <= nxt_state;
            run_mark <= nxt_mark;
            run_cnt  <= nxt_cnt;
        end
    end

    // Transitions and entry emission
    always_comb begin
        nxt_state = state;
        nxt_mark  = run_mark;
        nxt_cnt   = run_cnt;
        wr_en     = 1'b0;
        wr_data   = pack_entry(run_mark, run_cnt);
        if (!cfg_rx_en) begin
            nxt_state = ST_OFF;
            nxt_cnt   = '0;
        end else begin
            unique case (state)
                ST_OFF: nxt_state = ST_ARM;
                ST_ARM: if (strobe) begin
                    nxt_mark  = level;
                    nxt_cnt   = DUR_W'(1);
                    nxt_state = ST_RUN;
                end
                ST_RUN: if (strobe) begin
                    if (level != run_mark) begin
                        wr_en    = 1'b1;
                        nxt_mark = level;
                        nxt_cnt  = DUR_W'(1);
                    end else if (run_cnt == DUR_MAX) begin
                        if (cfg_ovf_en) begin
                            wr_en   = 1'b1;
                            nxt_cnt = DUR_W'(1);
                        end
                    end else begin
                        nxt_cnt = run_cnt + 1'b1;
                    end
                end
                default: nxt_state = ST_OFF;
            endcase
        end
    end

    // Interrupt output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rx_irq <= 1'b0;
        else if (wr_en && cfg_irq_en)  rx_irq <= 1'b1;
        else if (irq_clr)              rx_irq <= 1'b0;
    end
endmodule

// File: rtl/irrl_sampler_chk.sv
module irrl_sampler_chk #(
    parameter int DEPTH = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_rx_en,
    input logic                     cfg_irq_en,
    input logic                     irq_clr,
    input logic                     rx_irq,
    input logic [$clog2(DEPTH)-1:0] wr_ptr,
    input logic                     wr_en,
    input logic [7:0]               wr_data
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr != $past(wr_ptr)) |->
        (wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + 1'b1))); // R2

    AST_DUR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[6:0] != 7'd0)); // R1

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !irq_clr) |=> rx_irq); // R8

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_irq_en && !rx_irq) |=> !rx_irq); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rx_en |=> (wr_ptr == $past(wr_ptr))); // R7
endmodule

bind irrl_sampler irrl_sampler_chk #(.DEPTH(DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_irq_en(cfg_irq_en),
    .irq_clr(irq_clr), .rx_irq(rx_irq), .wr_ptr(wr_ptr),
    .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/test_irrl_sampler.sv
module test_irrl_sampler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       ir_in = 1'b0;
    logic       cfg_rx_en = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic       cfg_ovf_en = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [6:0] cfg_period = 7'd5;
    logic       irq_clr = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic [2:0] wr_ptr;
    logic       rx_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state built from the requirements
    logic [7:0] exp_buf [8];
    int         exp_ptr = 0;
    bit         exp_irq = 0;
    int         eff_p = 5;
    bit         in_run = 0;
    bit         cur_mark = 0;
    int         cur_len = 0;

    always #10 clk = ~clk;

    irrl_sampler i_irrl_sampler (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ir_in(ir_in),
        .cfg_rx_en(cfg_rx_en), .cfg_irq_en(cfg_irq_en), .cfg_ovf_en(cfg_ovf_en),
        .cfg_invert(cfg_invert), .cfg_period(cfg_period), .irq_clr(irq_clr),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] entry(input bit mark, input int dur);
        return {~mark, 7'(dur)};
    endfunction

    function automatic int close_len(input int len);
        if (cfg_ovf_en) return len - 127 * ((len - 1) / 127);
        return (len > 127) ? 127 : len;
    endfunction

    function automatic int split_cnt(input int len);
        return cfg_ovf_en ? (len - 1) / 127 : 0;
    endfunction

    task automatic push(input bit mark, input int dur);
        exp_buf[exp_ptr] = entry(mark, dur);
        exp_ptr = (exp_ptr + 1) % 8;
        if (cfg_irq_en) exp_irq = 1;
    endtask

    task automatic sample(input bit mark);
        @(negedge clk);
        ir_in = mark ^ cfg_invert;
        repeat (4) @(negedge clk);
        for (int t = 0; t < eff_p; t++) begin
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    // one run of n samples; polarity alternates between calls
    task automatic run(input bit mark, input int n);
        if (in_run) push(cur_mark, close_len(cur_len));
        for (int k = 0; k < split_cnt(n); k++) push(mark, 127);
        in_run = 1;
        cur_mark = mark;
        cur_len = n;
        for (int s = 0; s < n; s++) sample(mark);
    endtask

    task automatic set_en(input bit en);
        @(negedge clk);
        cfg_rx_en = en;
        if (!en) in_run = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        exp_irq = 0;
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        chk({req, " wr_ptr"}, wr_ptr, exp_ptr);
        chk({req, " rx_irq"}, rx_irq, exp_irq);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #2;
            chk({req, " slot"}, rd_data, exp_buf[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        for (int i = 0; i < 8; i++) exp_buf[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R10 reset");

        // R1 R2 R3 R8: basic runs, irq enabled
        cfg_period = 7'd5; eff_p = 5; cfg_ovf_en = 1; cfg_irq_en = 1;
        set_en(1);
        run(1, 3); run(0, 2); run(1, 1); run(0, 5); run(1, 1);
        check_all("R1 R3 basic runs");
        clear_irq();
        @(negedge clk);
        chk("R8 irq cleared", rx_irq, 0);
        // R5 R2: long runs split, pointer wraps
        run(0, 300); run(1, 130); run(0, 1);
        check_all("R5 split and R2 wrap");
        set_en(0);

        // R6: no splitting, saturation
        cfg_ovf_en = 0;
        set_en(1);
        run(1, 200); run(0, 4); run(1, 1);
        check_all("R6 saturate");
        set_en(0);

        // R7: idle line, then receiver restart
        cfg_ovf_en = 1;
        set_en(1);
        run(1, 2); run(0, 381);
        check_all("R7 idle spaces");
        set_en(0);
        for (int s = 0; s < 3; s++) sample(0);
        check_all("R7 disabled quiet");
        set_en(1);
        run(1, 2); run(0, 1);
        check_all("R7 fresh run");
        set_en(0);

        // R9: inverted line
        cfg_invert = 1;
        set_en(1);
        run(1, 4); run(0, 3); run(1, 1);
        check_all("R9 invert");
        set_en(0);
        cfg_invert = 0;

        // R8: interrupt masked
        clear_irq();
        cfg_irq_en = 0;
        set_en(1);
        run(1, 2); run(0, 2); run(1, 1);
        check_all("R8 masked");
        set_en(0);
        cfg_irq_en = 1;

        // R4: illegal period falls back to 50 ticks
        cfg_period = 7'd3; eff_p = 50;
        set_en(1);
        run(1, 2); run(0, 1);
        check_all("R4 default period");
        set_en(0);

        // R3 R5 R6: random runs with random period and split mode
        seed = $urandom(32'd4242);
        for (int b = 0; b < 3; b++) begin
            bit m;
            eff_p = 5 + int'($urandom % 8);
            cfg_period = 7'(eff_p);
            cfg_ovf_en = $urandom % 2;
            set_en(1);
            m = $urandom % 2;
            for (int r = 0; r < 5; r++) begin
                run(m, 1 + int'($urandom % 160));
                m = ~m;
            end
            run(m, 1);
            check_all("R3 R5 R6 random");
            set_en(0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule